// File: doc/BRIEF.md
# Read/Write Grouping Request Scheduler

This block keeps pending memory requests in one small age-ordered queue per bank. It chooses the next command for whichever bank the controller asks about. The aim is to serve reads in a run and writes in a run, so the data bus turns from write to read as rarely as possible. Each queued request carries a bank, a row, a column, a direction and a tag. The controller supplies the row that is currently open in every bank.

A single direction mode is shared by all banks. When the controller asks about a bank, the block looks at the current mode and picks the oldest request of that direction in the bank.
- If the pick matches the open row, the block issues a read or write command and drops the request from the queue.
- If the pick targets another row, the block reports a row miss and keeps the request queued.

Reads are held back when an older write in the same bank targets the same row and column. The block does not favour row hits, and it does not track DRAM timing.

Top module: `grp_sched`

## Requirements
- R1: A schedule request for a bank whose queue is empty yields cmd_o = 0 (NOP) and leaves the mode unchanged.
- R2: After reset the mode is read (read_mode_o = 1), all queues are empty, enq_ready_o = 1 and cmd_o = 0.
- R3: Before selecting, the mode switches to write when no read is queued in any bank, and switches to read when no write is queued in any bank. The selection in that same cycle uses the switched mode.
- R4: The block selects the oldest entry in the bank's queue whose direction matches the mode, and skips older entries of the other direction.
- R5: If the selected entry's row equals the bank's open row, cmd_o = 1 (READ) or 2 (WRITE). The entry's tag appears on cmd_tag_o and the entry leaves the queue.
- R6: If the selected entry's row differs from the open row, cmd_o = 3 (row miss) and cmd_row_o gives the wanted row. The entry stays queued and the mode is unchanged.
- R7: A selected read is blocked when an older write in the same bank has the same row and column. cmd_o is then NOP and the mode becomes write after the edge.
- R8: A selected write is never blocked by older reads to the same row and column.
- R9: If the bank holds no entry of the mode's direction, cmd_o is NOP and the mode inverts after the edge. The retry happens on a later request.
- R10: enq_ready_o is 0 while the bank named by enq_bank_i holds QDEPTH (8) entries. An enqueue offered then is dropped.
- R11: Removal keeps the age order of the remaining entries. An enqueue and a removal in the same cycle on one bank both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Offer a new request |
| enq_ready_o | output | 1 | Target bank queue has room |
| enq_bank_i | input | 2 | Bank of the new request |
| enq_row_i | input | 8 | Row of the new request |
| enq_col_i | input | 6 | Column of the new request |
| enq_write_i | input | 1 | 1 = write, 0 = read |
| enq_tag_i | input | 5 | Identifier returned on issue |
| sched_valid_i | input | 1 | Ask for a command for sched_bank_i |
| sched_bank_i | input | 2 | Bank being scheduled |
| open_row_i | input | 32 | Open row per bank, bank b at bits [8b+7:8b] |
| cmd_o | output | 2 | 0 NOP, 1 READ, 2 WRITE, 3 row miss |
| cmd_tag_o | output | 5 | Tag of the chosen entry (0 on NOP) |
| cmd_row_o | output | 8 | Row of the chosen entry (0 on NOP) |
| read_mode_o | output | 1 | Shared mode, 1 = read |

## Verification
The command, tag, row and enq_ready_o outputs are combinational. They are due in the same cycle the request or bank select is applied. The mode change and the queue update appear only after the next rising edge. The bench therefore drives its inputs at the falling edge and checks the combinational results one nanosecond later. It checks read_mode_o, and the queue contents as later commands reveal them, one nanosecond after the rising edge that commits them.

// File: rtl/grp_pkg.sv
package grp_pkg;
  parameter int NUM_BANKS = 4;
  parameter int QDEPTH    = 8;
  parameter int ROW_W     = 8;
  parameter int COL_W     = 6;
  parameter int TAG_W     = 5;

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = $clog2(QDEPTH);
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             wr;
    logic [TAG_W-1:0] tag;
  } entry_t;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_MISS  = 2'd3
  } cmd_e;
endpackage

// File: rtl/grp_bank_queue.sv
module grp_bank_queue
  import grp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  entry_t           push_entry_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  output entry_t           entry_o [QDEPTH],
  output logic [QDEPTH-1:0] valid_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  entry_t           mem_q   [QDEPTH];
  entry_t           shifted [QDEPTH];
  logic [CNT_W-1:0] wr_idx;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    if (i == QDEPTH - 1) begin : g_last
      assign shifted[i] = mem_q[i];
    end else begin : g_mid
      assign shifted[i] = mem_q[i+1];
    end
    assign valid_o[i] = CNT_W'(i) < cnt_q;
    assign entry_o[i] = mem_q[i];
  end

  assign full_o = cnt_q == CNT_W'(QDEPTH);
  // new entry lands behind the survivors of a same-cycle removal
  assign wr_idx = cnt_q - CNT_W'(pop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < QDEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (pop_i && (IDX_W'(i) >= pop_idx_i)) mem_q[i] <= shifted[i];
      end
      if (push_i) mem_q[wr_idx[IDX_W-1:0]] <= push_entry_i;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R10
  AST_POP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o[pop_idx_i]); // R5
  AST_PUSH_POP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q)); // R11
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
endmodule

// File: rtl/grp_pick.sv
module grp_pick
  import grp_pkg::*;
(
  input  entry_t            ent_i [QDEPTH],
  input  logic [QDEPTH-1:0] valid_i,
  input  logic              want_write_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hazard_o
);
  entry_t sel;

  // lowest index is oldest; scan downward so the oldest match wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (valid_i[i] && (ent_i[i].wr == want_write_i)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  assign sel = ent_i[idx_o];

  always_comb begin
    hazard_o = 1'b0;
    for (int j = 0; j < QDEPTH; j++) begin
      if (found_o && !want_write_i && (IDX_W'(j) < idx_o) && valid_i[j] &&
          ent_i[j].wr && (ent_i[j].row == sel.row) && (ent_i[j].col == sel.col))
        hazard_o = 1'b1;
    end
  end

  AST_PICK_IS_VALID: assert final (!found_o || valid_i[idx_o]); // R4
endmodule

// File: rtl/grp_sched.sv
module grp_sched
  import grp_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enq_valid_i,
  output logic                       enq_ready_o,
  input  logic [BANK_W-1:0]          enq_bank_i,
  input  logic [ROW_W-1:0]           enq_row_i,
  input  logic [COL_W-1:0]           enq_col_i,
  input  logic                       enq_write_i,
  input  logic [TAG_W-1:0]           enq_tag_i,
  input  logic                       sched_valid_i,
  input  logic [BANK_W-1:0]          sched_bank_i,
  input  logic [NUM_BANKS*ROW_W-1:0] open_row_i,
  output logic [1:0]                 cmd_o,
  output logic [TAG_W-1:0]           cmd_tag_o,
  output logic [ROW_W-1:0]           cmd_row_o,
  output logic                       read_mode_o
);
  entry_t            q_ent   [NUM_BANKS][QDEPTH];
  logic [QDEPTH-1:0] q_valid [NUM_BANKS];
  logic [NUM_BANKS-1:0] q_full, bank_any_wr, bank_any_rd;

  logic              read_mode_q, mode_d;
  logic              any_wr, any_rd, eff_read;
  logic              bank_empty, found, hazard, pop;
  logic [IDX_W-1:0]  pick_idx;
  logic [ROW_W-1:0]  open_sel;
  entry_t            pick_ent, enq_ent;
  cmd_e              cmd;

  assign enq_ent = '{row: enq_row_i, col: enq_col_i, wr: enq_write_i, tag: enq_tag_i};
  assign enq_ready_o = !q_full[enq_bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [QDEPTH-1:0] wr_bits;
    for (genvar i = 0; i < QDEPTH; i++) begin : g_bit
      assign wr_bits[i] = q_ent[b][i].wr;
    end
    assign bank_any_wr[b] = |(q_valid[b] & wr_bits);
    assign bank_any_rd[b] = |(q_valid[b] & ~wr_bits);

    grp_bank_queue u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (enq_valid_i && enq_ready_o && (enq_bank_i == BANK_W'(b))),
      .push_entry_i(enq_ent),
      .pop_i       (pop && (sched_bank_i == BANK_W'(b))),
      .pop_idx_i   (pick_idx),
      .entry_o     (q_ent[b]),
      .valid_o     (q_valid[b]),
      .full_o      (q_full[b])
    );
  end

  assign any_wr = |bank_any_wr;
  assign any_rd = |bank_any_rd;
  // mode after the pre-selection check for exhausted request types
  assign eff_read = read_mode_q ? any_rd : !any_wr;

  assign bank_empty = ~|q_valid[sched_bank_i];
  assign open_sel   = open_row_i[sched_bank_i*ROW_W +: ROW_W];

  grp_pick u_pick (
    .ent_i       (q_ent[sched_bank_i]),
    .valid_i     (q_valid[sched_bank_i]),
    .want_write_i(!eff_read),
    .found_o     (found),
    .idx_o       (pick_idx),
    .hazard_o    (hazard)
  );

  assign pick_ent = q_ent[sched_bank_i][pick_idx];

  always_comb begin
    cmd    = CMD_NOP;
    mode_d = read_mode_q;
    pop    = 1'b0;
    if (sched_valid_i && !bank_empty) begin
      mode_d = eff_read;
      if (!found) begin
        mode_d = !eff_read;          // retry in the other mode next request
      end else if (hazard) begin
        mode_d = 1'b0;
      end else if (pick_ent.row == open_sel) begin
        cmd = eff_read ? CMD_READ : CMD_WRITE;
        pop = 1'b1;
      end else begin
        cmd = CMD_MISS;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) read_mode_q <= 1'b1;
    else         read_mode_q <= mode_d;
  end

  assign cmd_o       = cmd;
  assign cmd_tag_o   = (cmd != CMD_NOP) ? pick_ent.tag : '0;
  assign cmd_row_o   = (cmd != CMD_NOP) ? pick_ent.row : '0;
  assign read_mode_o = read_mode_q;

  AST_EMPTY_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_valid_i && bank_empty) |-> cmd_o == 2'd0); // R1
  AST_EMPTY_HOLDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_valid_i && bank_empty) |=> $stable(read_mode_q)); // R1
  AST_HIT_ON_OPEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd1 || cmd_o == 2'd2) |-> cmd_row_o == open_sel); // R5
  AST_MISS_OFF_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd3) |-> cmd_row_o != open_sel); // R6
  AST_READ_IN_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd1) |-> (read_mode_q || !any_wr)); // R3
  AST_WRITE_IN_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd2) |-> (!read_mode_q || !any_rd)); // R3
  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sched_valid_i |-> (cmd_o == 2'd0 && $stable(read_mode_q) == $stable(read_mode_q))); // R1
endmodule

// File: tb/grp_sched_bench.sv
module grp_sched_bench;
  localparam int NB = 4, RW = 8, CW = 6, TW = 5, BW = 2, QD = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          enq_valid = 1'b0, enq_ready, enq_write = 1'b0;
  logic [BW-1:0] enq_bank = '0, sched_bank = '0;
  logic [RW-1:0] enq_row = '0, cmd_row;
  logic [CW-1:0] enq_col = '0;
  logic [TW-1:0] enq_tag = '0, cmd_tag;
  logic          sched_valid = 1'b0, read_mode;
  logic [1:0]    cmd;
  logic [NB-1:0][RW-1:0] open_rows = '0;
  logic [NB*RW-1:0] open_row;
  assign open_row = open_rows;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  grp_sched u_grp_sched (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_bank_i(enq_bank),
    .enq_row_i(enq_row), .enq_col_i(enq_col), .enq_write_i(enq_write), .enq_tag_i(enq_tag),
    .sched_valid_i(sched_valid), .sched_bank_i(sched_bank), .open_row_i(open_row),
    .cmd_o(cmd), .cmd_tag_o(cmd_tag), .cmd_row_o(cmd_row), .read_mode_o(read_mode)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic enq(int b, int row, int col, bit wr, int tag);
    @(negedge clk);
    sched_valid = 1'b0;
    enq_valid = 1'b1; enq_bank = BW'(b); enq_row = RW'(row);
    enq_col = CW'(col); enq_write = wr; enq_tag = TW'(tag);
    @(posedge clk); #1;
    enq_valid = 1'b0;
  endtask

  // cmd codes: 0 NOP, 1 READ, 2 WRITE, 3 row miss
  task automatic sched(int b, int ecmd, int etag, int erow, int emode, string req,
                       bit with_enq = 1'b0, int eb = 0, int erw = 0, int ecol = 0,
                       bit ewr = 1'b0, int etg = 0);
    @(negedge clk);
    enq_valid = with_enq; enq_bank = BW'(eb); enq_row = RW'(erw);
    enq_col = CW'(ecol); enq_write = ewr; enq_tag = TW'(etg);
    sched_valid = 1'b1; sched_bank = BW'(b);
    #1;
    check(req, "cmd", int'(cmd), ecmd);
    if (ecmd != 0) check(req, "tag", int'(cmd_tag), etag);
    if (ecmd == 3) check(req, "miss row", int'(cmd_row), erow);
    @(posedge clk); #1;
    sched_valid = 1'b0; enq_valid = 1'b0;
    check(req, "mode after", int'(read_mode), emode);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; #1;
    check("R2", "read mode", int'(read_mode), 1);
    check("R2", "enq ready", int'(enq_ready), 1);
    check("R2", "cmd", int'(cmd), 0);
  endtask

  task automatic t_empty;
    sched(2, 0, 0, 0, 1, "R1");
    sched(0, 0, 0, 0, 1, "R2 queues empty");
  endtask

  task automatic t_hit_miss;
    open_rows[0] = 8'd3;
    enq(0, 5, 1, 1'b0, 1);
    sched(0, 3, 1, 5, 1, "R6");
    sched(0, 3, 1, 5, 1, "R6 entry kept");
    open_rows[0] = 8'd5;
    sched(0, 1, 1, 0, 1, "R5");
    sched(0, 0, 0, 0, 1, "R5 entry removed");
  endtask

  task automatic t_grouping;
    open_rows[1] = 8'd1;
    enq(1, 1, 0, 1'b1, 2);
    enq(1, 1, 1, 1'b0, 3);
    enq(1, 1, 2, 1'b0, 4);
    enq(1, 1, 3, 1'b1, 5);
    sched(1, 1, 3, 0, 1, "R4");
    sched(1, 1, 4, 0, 1, "R4");
    sched(1, 2, 2, 0, 0, "R3 no reads left");
    sched(1, 2, 5, 0, 0, "R11 order");
    sched(1, 0, 0, 0, 0, "R1 write mode");
  endtask

  task automatic t_no_match;
    enq(0, 5, 4, 1'b0, 6);
    enq(2, 0, 0, 1'b1, 7);
    sched(0, 0, 0, 0, 1, "R9");
    sched(0, 1, 6, 0, 1, "R9 retry");
    sched(2, 2, 7, 0, 0, "R3 to write");
  endtask

  task automatic t_hazard;
    open_rows[3] = 8'd2;
    enq(0, 5, 0, 1'b0, 11);
    enq(3, 2, 7, 1'b1, 8);
    enq(3, 2, 7, 1'b0, 9);
    sched(0, 0, 0, 0, 1, "R9");
    sched(0, 1, 11, 0, 1, "R9 retry");
    sched(3, 0, 0, 0, 0, "R7");
    sched(3, 2, 8, 0, 0, "R7 write first");
    sched(3, 1, 9, 0, 1, "R3 to read");
  endtask

  task automatic t_write_no_hazard;
    enq(3, 2, 3, 1'b0, 12);
    enq(3, 2, 3, 1'b1, 13);
    enq(0, 5, 0, 1'b0, 14);
    enq(1, 1, 5, 1'b1, 15);
    sched(1, 0, 0, 0, 0, "R9");
    sched(3, 2, 13, 0, 0, "R8");
    sched(1, 2, 15, 0, 0, "R8");
    sched(3, 1, 12, 0, 1, "R3");
    sched(0, 1, 14, 0, 1, "R3");
  endtask

  task automatic t_full;
    for (int i = 0; i < QD; i++) enq(2, 0, i, 1'b1, 16 + i);
    @(negedge clk); enq_bank = 2'd2; #1;
    check("R10", "ready full bank", int'(enq_ready), 0);
    enq_bank = 2'd1; #1;
    check("R10", "ready other bank", int'(enq_ready), 1);
    enq(2, 0, 9, 1'b1, 31);
    sched(2, 2, 16, 0, 0, "R3 full drain");
    sched(2, 2, 17, 0, 0, "R11 push+pop", 1'b1, 2, 0, 9, 1'b1, 30);
    for (int i = 18; i < 24; i++) sched(2, 2, i, 0, 0, "R11 order");
    sched(2, 2, 30, 0, 0, "R11 pushed entry");
    sched(2, 0, 0, 0, 0, "R10 dropped entry");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty();
    t_hit_miss();
    t_grouping();
    t_no_match();
    t_hazard();
    t_write_no_hazard();
    t_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule